// File: doc/BRIEF.md
# Endian-aware load/store byte steering

This block sits between a register file data port and a byte-addressed memory data port. It decides which memory byte lanes an access touches, and in what order the register bytes map onto those lanes. It handles byte, halfword and word accesses. The byte order comes from two inputs. The first is a little-endian attribute that belongs to the storage region being accessed. The second is a per-instruction byte-reverse flag. On the data path the two inputs combine by exclusive-OR. On the instruction fetch path only the region attribute counts.

Each access supplies the following inputs: an access size code, the low address bits, the region attribute, the reverse flag, a fetch select and a store select. For stores, the block places the register bytes onto the memory lanes and raises the matching byte enables. For loads, it gathers the addressed lanes into a right-justified, zero-extended register value. An access that is misaligned or too large for the bus is flagged, and it produces no enables and no data. A parameter chooses whether the outputs are combinational or registered for one cycle.

Top module: `endian_byte_steer`

## Requirements
- R1: Memory lane k is bits [8k+7:8k] of the memory buses, and it holds the byte at address offset k. A normal word access in a region with region_le=0 and byte_rev=0 maps register bits [31:24] to lane 0 and register bits [7:0] to lane 3.
- R2: For data accesses, the effective byte reversal is region_le XOR byte_rev. A reversed word maps register bits [7:0] to lane 0. A byte-reversed access in a region with region_le=0 gives the same lanes as a normal access in a region with region_le=1. A byte-reversed access in a region with region_le=1 gives the normal order.
- R3: The size code is 0 for a byte, 1 for a halfword, 2 for a word and 3 for a doubleword. A halfword (acc_size=1) at offset 0 or 2 follows the same rule within its two lanes. Without reversal, register bits [15:8] go to the lower lane. With reversal, register bits [7:0] go to the lower lane.
- R4: A byte access (acc_size=0) uses lane addr_lo only. It maps register bits [7:0] to that lane whatever the values of region_le and byte_rev.
- R5: ld_data holds the addressed memory bytes, right-justified in the order of R1 to R3. Every register byte above the access size is zero.
- R6: mem_be has exactly the lanes covered by the access set. When is_store=1 and the access is data, mem_wdata carries the placed bytes, and every other lane is zero. When is_store=0, mem_wdata is zero.
- R7: An access is flagged with misalign=1 in three cases: a halfword at an odd offset, a word at a nonzero offset, or a size code larger than the bus (acc_size=3 on a 32-bit bus). A flagged access drives mem_be, mem_wdata and ld_data to zero.
- R8: When is_fetch=1, the access is treated as a word regardless of acc_size, and its order depends on region_le alone. byte_rev and is_store have no effect. mem_wdata is zero.
- R9: With OUT_REG=1, all outputs appear one clock after their inputs and are zero while rst_n is low. With OUT_REG=0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset |
| acc_size | input | 2 | Access size code, log2 of the byte count |
| addr_lo | input | OFF_W | Low address bits (byte offset within the bus) |
| region_le | input | 1 | Region little-endian attribute |
| byte_rev | input | 1 | Per-instruction byte-reverse flag |
| is_fetch | input | 1 | Instruction fetch select |
| is_store | input | 1 | Store select for a data access |
| reg_wdata | input | DATA_W | Register value to store |
| mem_rdata | input | DATA_W | Memory lanes read |
| mem_wdata | output | DATA_W | Memory lanes to write |
| mem_be | output | DATA_W/8 | Byte enables per lane |
| ld_data | output | DATA_W | Right-justified load value |
| misalign | output | 1 | Misaligned or oversized access |

## Verification
The assertions check four properties on every cycle. A flagged access leaves all outputs quiet. The enable count matches the access size. Lanes without an enable carry zero write data. Load bytes above the access size are zero, and fetches never write. Only the bench's sweep can show that each byte goes to the right lane. The sweep covers every size, offset, attribute, flag and fetch combination and compares against an arithmetic byte-order model. It also shows the equivalence of a reversed big-endian access and a normal little-endian access, and the one-cycle lag of the registered variant.

// File: rtl/endian_steer_pkg.sv
package endian_steer_pkg;
   localparam int SIZE_W     = 2;
   localparam int FETCH_SIZE = 2;   // instruction words are four bytes

   // byte count of a size code
   function automatic int size_bytes(input logic [SIZE_W-1:0] code);
      return 1 << code;
   endfunction
endpackage

// File: rtl/estr_ctrl.sv
module estr_ctrl
   import endian_steer_pkg::*;
#(
   parameter int LANES = 4,
   parameter int OFF_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SIZE_W-1:0] acc_size,
   input  logic [OFF_W-1:0]  addr_lo,
   input  logic              region_le,
   input  logic              byte_rev,
   input  logic              is_fetch,
   output logic              swap,
   output logic              misalign,
   output logic [OFF_W:0]    n_bytes,
   output logic [LANES-1:0]  be
);
   logic [SIZE_W-1:0] eff_size;
   int                nb;
   logic              legal;
   logic              aligned;

   always_comb begin
      eff_size = is_fetch ? SIZE_W'(FETCH_SIZE) : acc_size;
      swap     = region_le ^ (byte_rev & ~is_fetch);
      nb       = size_bytes(eff_size);
      legal    = (nb <= LANES);
      aligned  = ((int'(addr_lo) % nb) == 0);
      misalign = !(legal && aligned);
      n_bytes  = misalign ? '0 : (OFF_W+1)'(nb);
   end

   for (genvar k = 0; k < LANES; k++) begin : g_be
      assign be[k] = !misalign && (k >= int'(addr_lo)) && (k < int'(addr_lo) + nb);
   end

   // R7: flagged access raises no enable
   a_r7_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (be == '0));
   // R6: enable count equals access byte count
   a_r6_be_count: assert property (@(posedge clk) disable iff (!rst_n)
      !misalign |-> ($countones(be) == int'(n_bytes)));
   // R8: fetch always spans a full word
   a_r8_fetch_span: assert property (@(posedge clk) disable iff (!rst_n)
      (is_fetch && !misalign) |-> ($countones(be) == 4));
endmodule

// File: rtl/estr_store.sv
module estr_store #(
   parameter int LANES = 4,
   parameter int OFF_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               swap,
   input  logic [OFF_W-1:0]   off,
   input  logic [OFF_W:0]     n_bytes,
   input  logic [LANES-1:0]   be,
   input  logic [8*LANES-1:0] wreg,
   output logic [8*LANES-1:0] wdata
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [7:0] lane;
      int         pos;
      int         src;
      always_comb begin
         lane = 8'h00;
         pos  = k - int'(off);
         src  = swap ? pos : int'(n_bytes) - 1 - pos;
         if (en && be[k] && src >= 0 && src < LANES)
            lane = wreg[8*src +: 8];
      end
      assign wdata[8*k +: 8] = lane;

      // R6: lanes outside the access carry zero
      a_r6_quiet_lane: assert property (@(posedge clk) disable iff (!rst_n)
         !be[k] |-> (wdata[8*k +: 8] == 8'h00));
   end
endmodule

// File: rtl/estr_load.sv
module estr_load #(
   parameter int LANES = 4,
   parameter int OFF_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               swap,
   input  logic [OFF_W-1:0]   off,
   input  logic [OFF_W:0]     n_bytes,
   input  logic [8*LANES-1:0] rdata,
   output logic [8*LANES-1:0] ldata
);
   for (genvar j = 0; j < LANES; j++) begin : g_byte
      logic [7:0] b;
      int         lane;
      always_comb begin
         b    = 8'h00;
         lane = swap ? int'(off) + j : int'(off) + int'(n_bytes) - 1 - j;
         if (j < int'(n_bytes) && lane >= 0 && lane < LANES)
            b = rdata[8*lane +: 8];
      end
      assign ldata[8*j +: 8] = b;

      // R5: bytes above the access size are zero-filled
      a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
         (j >= int'(n_bytes)) |-> (ldata[8*j +: 8] == 8'h00));
   end
endmodule

// File: rtl/endian_byte_steer.sv
module endian_byte_steer
   import endian_steer_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int OUT_REG = 0,
   localparam int LANES  = DATA_W / 8,
   localparam int OFF_W  = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SIZE_W-1:0] acc_size,
   input  logic [OFF_W-1:0]  addr_lo,
   input  logic              region_le,
   input  logic              byte_rev,
   input  logic              is_fetch,
   input  logic              is_store,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [LANES-1:0]  mem_be,
   output logic [DATA_W-1:0] ld_data,
   output logic              misalign
);
   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_width
      $error("DATA_W must be 32 or 64");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg
      $error("OUT_REG must be 0 or 1");
   end

   logic              swap_c;
   logic              err_c;
   logic [OFF_W:0]    nb_c;
   logic [LANES-1:0]  be_c;
   logic [DATA_W-1:0] wd_c;
   logic [DATA_W-1:0] ld_c;
   logic              store_en;

   assign store_en = is_store & ~is_fetch;

   estr_ctrl #(.LANES(LANES), .OFF_W(OFF_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .acc_size(acc_size), .addr_lo(addr_lo),
      .region_le(region_le), .byte_rev(byte_rev), .is_fetch(is_fetch),
      .swap(swap_c), .misalign(err_c), .n_bytes(nb_c), .be(be_c));

   estr_store #(.LANES(LANES), .OFF_W(OFF_W)) store_i (
      .clk(clk), .rst_n(rst_n), .en(store_en), .swap(swap_c), .off(addr_lo),
      .n_bytes(nb_c), .be(be_c), .wreg(reg_wdata), .wdata(wd_c));

   estr_load #(.LANES(LANES), .OFF_W(OFF_W)) load_i (
      .clk(clk), .rst_n(rst_n), .swap(swap_c), .off(addr_lo),
      .n_bytes(nb_c), .rdata(mem_rdata), .ldata(ld_c));

   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_wdata <= '0;
            mem_be    <= '0;
            ld_data   <= '0;
            misalign  <= 1'b0;
         end else begin
            mem_wdata <= wd_c;
            mem_be    <= be_c;
            ld_data   <= ld_c;
            misalign  <= err_c;
         end
      end
   end else begin : g_comb
      assign mem_wdata = wd_c;
      assign mem_be    = be_c;
      assign ld_data   = ld_c;
      assign misalign  = err_c;
   end

   // R7: a flagged access leaves every output quiet
   a_r7_outputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (mem_be == '0 && mem_wdata == '0 && ld_data == '0));
   // R8: a fetch never produces write data
   a_r8_fetch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      is_fetch |-> (wd_c == '0));
endmodule

// File: tb/endian_byte_steer_tb.sv
module endian_byte_steer_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  acc_size = '0;
   logic [1:0]  addr_lo = '0;
   logic        region_le = 1'b0, byte_rev = 1'b0, is_fetch = 1'b0, is_store = 1'b0;
   logic [31:0] reg_wdata = '0, mem_rdata = '0;
   logic [31:0] wd_r, ld_r, wd_c, ld_c;
   logic [3:0]  be_r, be_c;
   logic        err_r, err_c;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   endian_byte_steer #(.DATA_W(32), .OUT_REG(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .acc_size(acc_size), .addr_lo(addr_lo),
      .region_le(region_le), .byte_rev(byte_rev), .is_fetch(is_fetch),
      .is_store(is_store), .reg_wdata(reg_wdata), .mem_rdata(mem_rdata),
      .mem_wdata(wd_r), .mem_be(be_r), .ld_data(ld_r), .misalign(err_r));

   endian_byte_steer #(.DATA_W(32), .OUT_REG(0)) dut_comb_i (
      .clk(clk), .rst_n(rst_n), .acc_size(acc_size), .addr_lo(addr_lo),
      .region_le(region_le), .byte_rev(byte_rev), .is_fetch(is_fetch),
      .is_store(is_store), .reg_wdata(reg_wdata), .mem_rdata(mem_rdata),
      .mem_wdata(wd_c), .mem_be(be_c), .ld_data(ld_c), .misalign(err_c));

   task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", what, got, exp);
      end
   endtask

   // arithmetic byte-order model
   task automatic model(input int sz, input int off, input bit le, input bit rev,
                        input bit fe, input bit st, input logic [31:0] rv,
                        input logic [31:0] mv, output logic [3:0] be,
                        output logic [31:0] wd, output logic [31:0] ld,
                        output logic err);
      int  n;
      bit  sw;
      int  s;
      int  sz_e;
      sz_e = fe ? 2 : sz;
      n    = 1 << sz_e;
      sw   = le ^ (rev && !fe);
      err  = (n > 4) || ((off % n) != 0);
      be = '0; wd = '0; ld = '0;
      if (!err) begin
         for (int i = 0; i < n; i++) begin
            s = sw ? 8*i : 8*(n-1-i);
            be[off+i] = 1'b1;
            if (st && !fe) wd[8*(off+i) +: 8] = rv[s +: 8];
            ld[s +: 8] = mv[8*(off+i) +: 8];
         end
      end
   endtask

   task automatic drive(input int sz, input int off, input bit le, input bit rev,
                        input bit fe, input bit st, input logic [31:0] rv,
                        input logic [31:0] mv);
      @(negedge clk);
      acc_size = 2'(sz); addr_lo = 2'(off); region_le = le; byte_rev = rev;
      is_fetch = fe; is_store = st; reg_wdata = rv; mem_rdata = mv;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [3:0]  e_be;
      logic [31:0] e_wd, e_ld;
      logic        e_err;
      string       tag;

      // R9: reset state of registered variant
      acc_size = 2'd2; is_store = 1'b1; reg_wdata = 32'h11121314;
      repeat (3) @(posedge clk);
      #1;
      check("R9 reset be", {28'h0, be_r}, 32'h0);
      check("R9 reset wdata", wd_r, 32'h0);
      check("R9 reset ld", ld_r, 32'h0);
      check("R9 reset err", {31'h0, err_r}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: normal word store, region_le=0
      drive(2, 0, 0, 0, 0, 1, 32'h11121314, 32'h0);
      check("R1 word BE store", wd_r, 32'h14131211);
      // R2: reversed in BE equals normal in LE
      drive(2, 0, 0, 1, 0, 1, 32'h11121314, 32'h0);
      check("R2 reversed BE store", wd_r, 32'h11121314);
      drive(2, 0, 1, 0, 0, 1, 32'h11121314, 32'h0);
      check("R2 normal LE store", wd_r, 32'h11121314);
      drive(2, 0, 1, 1, 0, 1, 32'h11121314, 32'h0);
      check("R2 reversed LE store", wd_r, 32'h14131211);

      // R9: registered output lags the combinational one by a cycle
      @(negedge clk);
      byte_rev = 1'b0; region_le = 1'b0; reg_wdata = 32'hA1B2C3D4;
      #1;
      check("R9 comb follows", wd_c, 32'hD4C3B2A1);
      check("R9 reg holds", wd_r, 32'h14131211);
      @(posedge clk);
      #1;
      check("R9 reg updates", wd_r, 32'hD4C3B2A1);

      // full sweep
      for (int fe = 0; fe < 2; fe++)
      for (int st = 0; st < 2; st++)
      for (int le = 0; le < 2; le++)
      for (int rv = 0; rv < 2; rv++)
      for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 4; off++)
      for (int p = 0; p < 2; p++) begin
         logic [31:0] rvv, mvv;
         rvv = (p == 0) ? 32'h8192A3B4 : 32'h5E6F7081;
         mvv = (p == 0) ? 32'hC5D6E7F8 : 32'h0A1B2C3D;
         drive(sz, off, le[0], rv[0], fe[0], st[0], rvv, mvv);
         model(sz, off, le[0], rv[0], fe[0], st[0], rvv, mvv, e_be, e_wd, e_ld, e_err);
         if (e_err)        tag = "R7";
         else if (fe != 0) tag = "R8";
         else if (sz == 0) tag = "R4";
         else if (sz == 1) tag = "R3";
         else if ((le ^ rv) != 0) tag = "R2";
         else              tag = "R1";
         check($sformatf("%s/R6 be sz%0d off%0d le%0d rev%0d fe%0d", tag, sz, off, le, rv, fe),
               {28'h0, be_r}, {28'h0, e_be});
         check($sformatf("%s/R6 wdata sz%0d off%0d le%0d rev%0d fe%0d st%0d", tag, sz, off, le, rv, fe, st),
               wd_r, e_wd);
         check($sformatf("%s/R5 ld sz%0d off%0d le%0d rev%0d fe%0d", tag, sz, off, le, rv, fe),
               ld_r, e_ld);
         check($sformatf("R7 err sz%0d off%0d fe%0d", sz, off, fe), {31'h0, err_r}, {31'h0, e_err});
         check($sformatf("R9 comb be %s", tag), {28'h0, be_c}, {28'h0, e_be});
         check($sformatf("R9 comb wdata %s", tag), wd_c, e_wd);
         check($sformatf("R9 comb ld %s", tag), ld_c, e_ld);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule